// File: doc/BRIEF.md
# Power-Good Qualification and Deglitch Controller

This block decides when a load switch may report its output rail as good. It takes the digital results of two threshold comparators on the sensed rail voltage: one set above a rising threshold, one set below a lower falling threshold. It also takes a completion flag from the gate driver's soft-start sequence and a set of fault flags. From these it drives a single active-high `pwr_good` output. Changes in both directions are filtered by programmable deglitch windows, one for assertion and one for de-assertion.

The response to faults depends on the `BREAKER_MODE` parameter, which selects one of two variants. In the clamping variant (`BREAKER_MODE` = 0) the switch stays on through overvoltage and persistent overload, so power-good keeps tracking the comparators. In the breaker variant (`BREAKER_MODE` = 1) those two events switch the load off and pull power-good low.

Undervoltage, overtemperature and a shorted current-limit setting pin pull power-good low in both variants. An open current-limit pin is only acted on after an extra blanking interval. Short overcurrent events never pull power-good low. All time values are counted in clock cycles.

Top module: `pwr_good_ctl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `pwr_good` is 0.
- R2: `pwr_good` never rises while `inrush_done` is 0, no matter how long `above_rise` is 1.
- R3: With `pwr_good` low, `inrush_done`=1, `above_rise`=1 and no switch-off fault, `pwr_good` rises on the ASSERT_CYC-th clock edge of that condition and not before.
- R4: With `pwr_good` high, `below_fall`=1 held for DEASSERT_CYC consecutive edges drives `pwr_good` to 0 on the last of those edges.
- R5: `oc_evt` has no effect: with `pwr_good` high and no other drop cause, raising `oc_evt` leaves `pwr_good` at 1.
- R6: With `BREAKER_MODE`=0, `ov_flt` or `overload_flt` leaves `pwr_good` at 1. With `BREAKER_MODE`=1, either flag held for DEASSERT_CYC edges drives `pwr_good` to 0, and it cannot rise again while the flag is held.
- R7: `uv_flt`, `ot_flt` or `ilim_short_flt` held for DEASSERT_CYC edges drives `pwr_good` to 0 in both variants. While any of them is held, `pwr_good` stays 0.
- R8: Hysteresis: once `pwr_good` is high, `above_rise` returning to 0 does not lower it; only `below_fall` or a fault does.
- R9: If the pending condition drops for one edge before its window completes, the window restarts and `pwr_good` does not change.
- R10: `ilim_open_flt` held for BLANK_CYC + DEASSERT_CYC edges drives `pwr_good` to 0 on the last edge. If it is removed one edge earlier, `pwr_good` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inrush_done | input | 1 | Gate driver has finished its soft-start |
| above_rise | input | 1 | Sensed rail is above the rising threshold |
| below_fall | input | 1 | Sensed rail is below the falling threshold |
| uv_flt | input | 1 | Undervoltage fault |
| ov_flt | input | 1 | Overvoltage event |
| ot_flt | input | 1 | Overtemperature fault |
| overload_flt | input | 1 | Persistent overload event |
| ilim_short_flt | input | 1 | Current-limit setting pin shorted to ground |
| ilim_open_flt | input | 1 | Current-limit setting pin open |
| oc_evt | input | 1 | Transient overcurrent or fast-trip event |
| pwr_good | output | 1 | Qualified power-good, active high |

## Verification
A transient overcurrent indication can arrive in the very cycle the rail falls through the falling threshold, so one input that must be ignored lands next to one that must be acted on. The bench raises `oc_evt` together with `below_fall` and requires `pwr_good` to be high after DEASSERT_CYC-1 edges and low after exactly DEASSERT_CYC edges. Any other timing would mean the overcurrent flag either shortened the window or restarted it. A second overlap is an open-pin blanking window that expires while the de-assert window would otherwise run on. The bench judges it by removing the fault one edge before the summed delay completes.

// File: rtl/pwr_good_ctl.sv
module pwr_good_ctl #(
  parameter bit          BREAKER_MODE = 1'b0,
  parameter int unsigned ASSERT_CYC   = 16,
  parameter int unsigned DEASSERT_CYC = 8,
  parameter int unsigned BLANK_CYC    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inrush_done,
  input  logic above_rise,
  input  logic below_fall,
  input  logic uv_flt,
  input  logic ov_flt,
  input  logic ot_flt,
  input  logic overload_flt,
  input  logic ilim_short_flt,
  input  logic ilim_open_flt,
  input  logic oc_evt,
  output logic pwr_good
);

  localparam int unsigned MAXC = (ASSERT_CYC > DEASSERT_CYC) ? ASSERT_CYC : DEASSERT_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned BW   = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD_UP   = CW'(ASSERT_CYC - 1);
  localparam logic [CW-1:0] LOAD_DN   = CW'(DEASSERT_CYC - 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

  logic [CW-1:0] dly_q;
  logic [BW-1:0] blank_q;
  logic          pg_q;

  // overcurrent is accepted at the pin but never qualifies anything
  logic unused_oc;
  assign unused_oc = oc_evt;

  logic mode_off, hard_off, open_late, go_up, go_dn, want;

  assign mode_off  = BREAKER_MODE & (ov_flt | overload_flt);
  assign hard_off  = uv_flt | ot_flt | ilim_short_flt | mode_off;
  assign open_late = ilim_open_flt & (blank_q == BLANK_END);
  assign go_up     = inrush_done & above_rise & ~hard_off & ~ilim_open_flt;
  assign go_dn     = below_fall | hard_off | open_late;
  assign want      = pg_q ? go_dn : go_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 blank_q <= '0;
    else if (!ilim_open_flt)    blank_q <= '0;
    else if (blank_q != BLANK_END) blank_q <= blank_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q  <= 1'b0;
      dly_q <= LOAD_UP;
    end else if (!want) begin
      dly_q <= pg_q ? LOAD_DN : LOAD_UP;
    end else if (dly_q == '0) begin
      pg_q  <= ~pg_q;
      dly_q <= pg_q ? LOAD_UP : LOAD_DN;
    end else begin
      dly_q <= dly_q - CW'(1);
    end
  end

  assign pwr_good = pg_q;

endmodule

// File: rtl/pwr_good_ctl_chk.sv
module pwr_good_ctl_chk #(
  parameter bit          BREAKER_MODE = 1'b0,
  parameter int unsigned DEASSERT_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic inrush_done,
  input logic above_rise,
  input logic below_fall,
  input logic uv_flt,
  input logic ov_flt,
  input logic ot_flt,
  input logic overload_flt,
  input logic ilim_short_flt,
  input logic ilim_open_flt,
  input logic pwr_good
);

  localparam int unsigned HW = $clog2(DEASSERT_CYC + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(DEASSERT_CYC);

  logic [HW-1:0] hold_q;
  logic          severe, drop_cause;

  assign severe     = uv_flt | ot_flt | ilim_short_flt;
  assign drop_cause = below_fall | severe | ilim_open_flt |
                      (BREAKER_MODE & (ov_flt | overload_flt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hold_q <= '0;
    else if (!severe)      hold_q <= '0;
    else if (hold_q != HOLD_END) hold_q <= hold_q + HW'(1);
  end

  p_rise_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(inrush_done && above_rise && !severe));

  p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_good) |-> $past(drop_cause));

  p_oc_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !drop_cause) |=> pwr_good);

  p_hard_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q == HOLD_END) |-> !pwr_good);

endmodule

bind pwr_good_ctl pwr_good_ctl_chk #(
  .BREAKER_MODE(BREAKER_MODE),
  .DEASSERT_CYC(DEASSERT_CYC)
) u_chk (.*);

// File: tb/pwr_good_ctl_bench.sv
module pwr_good_ctl_bench;

  localparam int TA = 12;
  localparam int TD = 5;
  localparam int TB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inrush_done = 1'b0, above_rise = 1'b0, below_fall = 1'b0;
  logic uv_flt = 1'b0, ov_flt = 1'b0, ot_flt = 1'b0, overload_flt = 1'b0;
  logic ilim_short_flt = 1'b0, ilim_open_flt = 1'b0, oc_evt = 1'b0;
  logic pg_c, pg_b;

  always #4 clk = ~clk;

  pwr_good_ctl #(.BREAKER_MODE(1'b0), .ASSERT_CYC(TA), .DEASSERT_CYC(TD), .BLANK_CYC(TB)) u_pwr_good_ctl (
    .clk(clk), .rst_n(rst_n), .inrush_done(inrush_done), .above_rise(above_rise),
    .below_fall(below_fall), .uv_flt(uv_flt), .ov_flt(ov_flt), .ot_flt(ot_flt),
    .overload_flt(overload_flt), .ilim_short_flt(ilim_short_flt),
    .ilim_open_flt(ilim_open_flt), .oc_evt(oc_evt), .pwr_good(pg_c));

  pwr_good_ctl #(.BREAKER_MODE(1'b1), .ASSERT_CYC(TA), .DEASSERT_CYC(TD), .BLANK_CYC(TB)) u_pwr_good_ctl_cb (
    .clk(clk), .rst_n(rst_n), .inrush_done(inrush_done), .above_rise(above_rise),
    .below_fall(below_fall), .uv_flt(uv_flt), .ov_flt(ov_flt), .ot_flt(ot_flt),
    .overload_flt(overload_flt), .ilim_short_flt(ilim_short_flt),
    .ilim_open_flt(ilim_open_flt), .oc_evt(oc_evt), .pwr_good(pg_b));

  typedef struct {
    int    due;
    bit    exp_c;
    bit    exp_b;
    string tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int k, input bit ec, input bit eb, input string tag);
    item_t it;
    it.due = cyc + k; it.exp_c = ec; it.exp_b = eb; it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    item_t it;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it = sbq.pop_front();
      checks += 2;
      if (pg_c !== it.exp_c) begin
        errors++;
        $display("FAIL %s clamp variant: pwr_good=%0b expected %0b (cycle %0d)", it.tag, pg_c, it.exp_c, cyc);
      end
      if (pg_b !== it.exp_b) begin
        errors++;
        $display("FAIL %s breaker variant: pwr_good=%0b expected %0b (cycle %0d)", it.tag, pg_b, it.exp_b, cyc);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fault(input int id, input logic v);
    case (id)
      0: uv_flt = v;
      1: ot_flt = v;
      2: ilim_short_flt = v;
      3: ov_flt = v;
      4: overload_flt = v;
      default: ilim_open_flt = v;
    endcase
  endtask

  task automatic reassert(input string tag);
    below_fall = 1'b0;
    above_rise = 1'b1;
    expect_at(TA - 1, 1'b0, 1'b0, tag);
    expect_at(TA, 1'b1, 1'b1, tag);
    tick(TA + 2);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run reached cycle %0d, expected to end well before", cyc);
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R1 after reset release");
    tick(2);

    // R2: rail good but soft-start not finished
    above_rise = 1'b1;
    expect_at(TA + 3, 1'b0, 1'b0, "R2 no inrush_done");
    tick(TA + 5);

    // R9: rising window interrupted one edge early
    inrush_done = 1'b1;
    tick(TA - 1);
    above_rise = 1'b0;
    expect_at(2, 1'b0, 1'b0, "R9 assert window restart");
    tick(3);

    // R3: full assertion window
    reassert("R3 assertion window");

    // R8: rising comparator drops, falling comparator quiet
    above_rise = 1'b0;
    expect_at(TA + TD + 3, 1'b1, 1'b1, "R8 hysteresis hold");
    tick(TA + TD + 4);
    above_rise = 1'b1;

    // R5: overcurrent alone
    oc_evt = 1'b1;
    expect_at(TD + 4, 1'b1, 1'b1, "R5 overcurrent ignored");
    tick(TD + 6);
    oc_evt = 1'b0;

    // R9: de-assert window interrupted one edge early
    above_rise = 1'b0;
    below_fall = 1'b1;
    tick(TD - 1);
    below_fall = 1'b0;
    expect_at(2, 1'b1, 1'b1, "R9 deassert window restart");
    tick(3);

    // R4 with coincident overcurrent (R5)
    below_fall = 1'b1;
    oc_evt = 1'b1;
    expect_at(TD - 1, 1'b1, 1'b1, "R4 before deassert window end");
    expect_at(TD, 1'b0, 1'b0, "R4 deassert with R5 overcurrent");
    tick(TD + 2);
    oc_evt = 1'b0;
    reassert("R3 reassert after R4");

    // R6: overvoltage then persistent overload
    for (int f = 3; f <= 4; f++) begin
      set_fault(f, 1'b1);
      expect_at(TD - 1, 1'b1, 1'b1, "R6 variant event, before window end");
      expect_at(TD, 1'b1, 1'b0, "R6 variant event");
      expect_at(TD + TA + 2, 1'b1, 1'b0, "R6 held off while event persists");
      tick(TD + TA + 4);
      set_fault(f, 1'b0);
      expect_at(TA - 1, 1'b1, 1'b0, "R6 breaker recovery before window");
      expect_at(TA, 1'b1, 1'b1, "R6 breaker recovery");
      tick(TA + 2);
    end

    // R7: undervoltage, overtemperature, shorted limit pin
    for (int f = 0; f <= 2; f++) begin
      set_fault(f, 1'b1);
      expect_at(TD - 1, 1'b1, 1'b1, "R7 before window end");
      expect_at(TD, 1'b0, 1'b0, "R7 switch-off fault");
      expect_at(TD + TA + 2, 1'b0, 1'b0, "R7 held low while fault persists");
      tick(TD + TA + 4);
      set_fault(f, 1'b0);
      reassert("R3 reassert after R7");
    end

    // R10: open limit pin, removed one edge early, then held
    set_fault(5, 1'b1);
    tick(TB + TD - 1);
    set_fault(5, 1'b0);
    expect_at(2, 1'b1, 1'b1, "R10 open pin removed early");
    tick(4);
    set_fault(5, 1'b1);
    expect_at(TB + TD - 1, 1'b1, 1'b1, "R10 before blank plus deassert");
    expect_at(TB + TD, 1'b0, 1'b0, "R10 open pin after blank plus deassert");
    tick(TB + TD + 3);
    set_fault(5, 1'b0);
    reassert("R3 reassert after R10");

    // R1: reset while high
    rst_n = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R1 reset while high");
    tick(2);
    rst_n = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R1 first cycle after release");
    expect_at(TA, 1'b1, 1'b1, "R3 assert after reset");
    tick(TA + 3);

    if (sbq.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard R1: %0d items left, expected 0", sbq.size());
    end
    summary();
  end

endmodule